// File: doc/BRIEF.md
# Binary Clock Raster Renderer

This block produces a 640x480, 60 Hz raster (horizontal sync, vertical sync and a visible-area flag) and paints the current time on it as a binary clock. The time arrives as six BCD digits. Each digit gets its own column of four squares. A square is lit when the matching bit of the digit is set, and drawn dim when that bit is clear. Squares for bit positions that a digit can never reach are not drawn at all. The columns run, left to right, tens of hours, hours, tens of minutes, minutes, tens of seconds, seconds.

The picture is computed from the digit inputs on every pixel. A new time therefore shows up in the same frame, with no latching. Two single-cycle request inputs step through four grid layouts and four colour schemes, and both wrap around. The colour channels are two bits each, and the same signals are also packed into one output byte for an 8-pin video connector. The time base, the buttons and the pixel clock sit outside this block.

Top module: `binclock_vga`

## Requirements
- R1: A line lasts H_VISIBLE+H_FRONT+H_SYNC+H_BACK clocks (800 by default), counted from 0. `hsync` is low for clocks H_VISIBLE+H_FRONT up to H_VISIBLE+H_FRONT+H_SYNC-1 (656 to 751 by default) and high otherwise. After reset, position (0,0) is presented until the first clock edge.
- R2: A frame lasts V_VISIBLE+V_FRONT+V_SYNC+V_BACK lines (525 by default). `vsync` is low on lines V_VISIBLE+V_FRONT to V_VISIBLE+V_FRONT+V_SYNC-1 (490 and 491 by default).
- R3: `de` is high exactly when the clock in the line is below H_VISIBLE and the line is below V_VISIBLE. Red, green and blue are 0 whenever `de` is low.
- R4: The square size S is SQ, or 2*SQ when layout bit 1 is set. The gap G is GAP, or 2*GAP when layout bit 0 is set. Let P = S+G. Column c (0 to 5) covers x from X0+c*P to X0+c*P+S-1. Row r (0 to 3) covers y from Y0+r*P to Y0+r*P+S-1 and shows bit 3-r, so the most significant bit is at the top. `digits[23:20]` drives column 0 and `digits[3:0]` drives column 5, four bits per column.
- R5: Inside a drawn square the pixel takes the scheme's foreground colour when the bit is 1 and its dim colour when the bit is 0. Every other visible pixel takes the background colour.
- R6: Valid bit positions per column are: 1..0 for column 0, 2..0 for columns 2 and 4, and 3..0 for columns 1, 3 and 5. A square outside these is painted background, whatever the digit value.
- R7: A high `layout_step` at a clock edge advances the 2-bit layout index by one, wrapping from 3 to 0. Otherwise the index holds.
- R8: A high `color_step` at a clock edge advances the 2-bit scheme index by one, wrapping from 3 to 0. Colours are written {R,G,B}, two bits each, as foreground/dim/background. Scheme 0: 111111/010101/000000. Scheme 1: 001100/000100/000000. Scheme 2: 111000/010000/000001. Scheme 3: 001011/000001/010101.
- R9: `vga_byte` bits 0 to 7 carry red[1], green[1], blue[1], vsync, red[0], green[0], blue[0], hsync.
- R10: A change on `digits` reaches the colour outputs at the next pixel drawn, with no frame latency.
- R11: Reset (`rst_n` low, asynchronous) returns the beam to (0,0) and both indices to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digits | input | 24 | BCD time, HH MM SS, most significant digit at the top |
| layout_step | input | 1 | Advance layout index (one pulse, one step) |
| color_step | input | 1 | Advance colour scheme index (one pulse, one step) |
| red | output | 2 | Red intensity |
| green | output | 2 | Green intensity |
| blue | output | 2 | Blue intensity |
| hsync | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active low |
| de | output | 1 | Beam inside visible region |
| vga_byte | output | 8 | Packed connector byte |

## Verification
The bench builds the block with a 64x40 visible area, an 80-clock line and a 46-line frame, with grid origin 2, square 4 and gap 2. At that size every pixel of a whole frame can be compared against the model in a few thousand cycles, for each combination of time, layout and scheme. In the largest layout the grid runs past the right and bottom edges of the visible area, so the blanking of squares cut off by the visible edge is covered as well.

// File: rtl/binclock_vga.sv
module binclock_vga #(
  parameter int H_VISIBLE = 640,
  parameter int H_FRONT   = 16,
  parameter int H_SYNC    = 96,
  parameter int H_BACK    = 48,
  parameter int V_VISIBLE = 480,
  parameter int V_FRONT   = 10,
  parameter int V_SYNC    = 2,
  parameter int V_BACK    = 33,
  parameter int X0        = 96,
  parameter int Y0        = 80,
  parameter int SQ        = 48,
  parameter int GAP       = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] digits,
  input  logic        layout_step,
  input  logic        color_step,
  output logic [1:0]  red,
  output logic [1:0]  green,
  output logic [1:0]  blue,
  output logic        hsync,
  output logic        vsync,
  output logic        de,
  output logic [7:0]  vga_byte
);
  localparam int H_TOTAL = H_VISIBLE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_VISIBLE + V_FRONT + V_SYNC + V_BACK;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [23:0] VALID = 24'h3F7F7F;

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [1:0]    lay_idx, pal_idx;
  wire line_end = (hcnt == HW'(H_TOTAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt    <= '0;
      vcnt    <= '0;
      lay_idx <= '0;
      pal_idx <= '0;
    end else begin
      if (line_end) begin
        hcnt <= '0;
        vcnt <= (vcnt == VW'(V_TOTAL - 1)) ? '0 : vcnt + VW'(1);
      end else begin
        hcnt <= hcnt + HW'(1);
      end
      if (layout_step) lay_idx <= lay_idx + 2'd1;
      if (color_step)  pal_idx <= pal_idx + 2'd1;
    end
  end

  assign hsync = !(hcnt >= HW'(H_VISIBLE + H_FRONT) && hcnt < HW'(H_VISIBLE + H_FRONT + H_SYNC));
  assign vsync = !(vcnt >= VW'(V_VISIBLE + V_FRONT) && vcnt < VW'(V_VISIBLE + V_FRONT + V_SYNC));
  assign de    = (hcnt < HW'(H_VISIBLE)) && (vcnt < VW'(V_VISIBLE));

  wire [15:0] hx    = 16'(hcnt);
  wire [15:0] vy    = 16'(vcnt);
  wire [15:0] sq    = lay_idx[1] ? 16'(2 * SQ) : 16'(SQ);
  wire [15:0] pitch = sq + (lay_idx[0] ? 16'(2 * GAP) : 16'(GAP));

  logic [3:0] row_hit;
  logic [5:0] cell_on, cell_lit;

  for (genvar r = 0; r < 4; r++) begin : g_row
    wire [15:0] ys = 16'(Y0) + 16'(r) * pitch;
    assign row_hit[3-r] = (vy >= ys) && (vy < ys + sq);
  end

  for (genvar c = 0; c < 6; c++) begin : g_col
    wire [15:0] xs   = 16'(X0) + 16'(c) * pitch;
    wire        in_x = (hx >= xs) && (hx < xs + sq);
    wire [3:0]  shown = row_hit & VALID[23-4*c -: 4];
    assign cell_on[c]  = in_x && |shown;
    assign cell_lit[c] = in_x && |(shown & digits[23-4*c -: 4]);
  end

  logic [5:0] fg, dim, bg, pix;
  always_comb begin
    case (pal_idx)
      2'd0: begin fg = 6'b111111; dim = 6'b010101; bg = 6'b000000; end
      2'd1: begin fg = 6'b001100; dim = 6'b000100; bg = 6'b000000; end
      2'd2: begin fg = 6'b111000; dim = 6'b010000; bg = 6'b000001; end
      default: begin fg = 6'b001011; dim = 6'b000001; bg = 6'b010101; end
    endcase
    if (!de)             pix = 6'b0;
    else if (|cell_lit)  pix = fg;
    else if (|cell_on)   pix = dim;
    else                 pix = bg;
  end

  assign red      = pix[5:4];
  assign green    = pix[3:2];
  assign blue     = pix[1:0];
  assign vga_byte = {hsync, blue[0], green[0], red[0], vsync, blue[1], green[1], red[1]};

  p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n) line_end |=> hcnt == '0);
  p_vhold_r2: assert property (@(posedge clk) disable iff (!rst_n) !line_end |=> $stable(vcnt));
  p_vsync_edge_r2: assert property (@(posedge clk) disable iff (!rst_n) (hcnt != '0) |-> $stable(vsync));
  p_sync_blank_r3: assert property (@(posedge clk) disable iff (!rst_n) !hsync |-> !de);
  p_lay_step_r7: assert property (@(posedge clk) disable iff (!rst_n) layout_step |=> lay_idx == $past(lay_idx) + 2'd1);
  p_lay_hold_r7: assert property (@(posedge clk) disable iff (!rst_n) !layout_step |=> $stable(lay_idx));
  p_pal_step_r8: assert property (@(posedge clk) disable iff (!rst_n) color_step |=> pal_idx == $past(pal_idx) + 2'd1);
  p_pal_hold_r8: assert property (@(posedge clk) disable iff (!rst_n) !color_step |=> $stable(pal_idx));
endmodule

// File: tb/binclock_vga_tb.sv
module binclock_vga_tb;
  localparam int HV = 64, HF = 4, HS = 8, HB = 4;
  localparam int VV = 40, VF = 2, VS = 2, VB = 2;
  localparam int X0 = 2, Y0 = 2, SQ = 4, GAP = 2;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int FRAME = HT * VT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [23:0] digits = '0;
  logic layout_step = 1'b0, color_step = 1'b0;
  logic [1:0] red, green, blue;
  logic hsync, vsync, de;
  logic [7:0] vga_byte;

  binclock_vga #(.H_VISIBLE(HV), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
                 .V_VISIBLE(VV), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
                 .X0(X0), .Y0(Y0), .SQ(SQ), .GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .digits(digits), .layout_step(layout_step),
    .color_step(color_step), .red(red), .green(green), .blue(blue),
    .hsync(hsync), .vsync(vsync), .de(de), .vga_byte(vga_byte));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int mh = 0, mv = 0, mlay = 0, mcol = 0;
  int bad_rgb, bad_sync, bad_de, bad_byte;

  // R8 scheme table, {fg, dim, bg}
  function automatic logic [5:0] scheme(int s, int cls);
    logic [17:0] t;
    case (s)
      0: t = {6'b111111, 6'b010101, 6'b000000};
      1: t = {6'b001100, 6'b000100, 6'b000000};
      2: t = {6'b111000, 6'b010000, 6'b000001};
      default: t = {6'b001011, 6'b000001, 6'b010101};
    endcase
    return cls == 2 ? t[17:12] : (cls == 1 ? t[11:6] : t[5:0]);
  endfunction

  // R3-R6 pixel model
  function automatic logic [5:0] exp_rgb(int x, int y, logic [23:0] t, int lay, int sch);
    int s, p, cls;
    logic [3:0] ok, d;
    if (x >= HV || y >= VV) return 6'b0;
    s = (lay >= 2) ? 2 * SQ : SQ;
    p = s + ((lay % 2 == 1) ? 2 * GAP : GAP);
    cls = 0;
    for (int c = 0; c < 6; c++) begin
      if (x >= X0 + c * p && x < X0 + c * p + s) begin
        ok = (c == 0) ? 4'b0011 : ((c % 2 == 0) ? 4'b0111 : 4'b1111);
        d = t[23 - 4 * c -: 4];
        for (int r = 0; r < 4; r++)
          if (y >= Y0 + r * p && y < Y0 + r * p + s && ok[3 - r])
            cls = d[3 - r] ? 2 : 1;
      end
    end
    return scheme(sch, cls);
  endfunction

  task automatic compare();
    logic [5:0] e;
    logic eh, ev, ed;
    logic [7:0] eb;
    e  = exp_rgb(mh, mv, digits, mlay, mcol);
    eh = !(mh >= HV + HF && mh < HV + HF + HS);
    ev = !(mv >= VV + VF && mv < VV + VF + VS);
    ed = (mh < HV) && (mv < VV);
    eb = {eh, e[0], e[2], e[4], ev, e[1], e[3], e[5]};
    if ({red, green, blue} !== e) begin
      if (bad_rgb == 0) $display("FAIL R4/R5/R6 rgb at (%0d,%0d): got %b exp %b", mh, mv, {red, green, blue}, e);
      bad_rgb++;
    end
    if (hsync !== eh || vsync !== ev) begin
      if (bad_sync == 0) $display("FAIL R1/R2 sync at (%0d,%0d): got %b%b exp %b%b", mh, mv, hsync, vsync, eh, ev);
      bad_sync++;
    end
    if (de !== ed) begin
      if (bad_de == 0) $display("FAIL R3 de at (%0d,%0d): got %b exp %b", mh, mv, de, ed);
      bad_de++;
    end
    if (vga_byte !== eb) begin
      if (bad_byte == 0) $display("FAIL R9 byte at (%0d,%0d): got %h exp %h", mh, mv, vga_byte, eb);
      bad_byte++;
    end
  endtask

  task automatic cyc(bit chk);
    if (chk) compare();
    mh++;
    if (mh == HT) begin mh = 0; mv = (mv == VT - 1) ? 0 : mv + 1; end
    @(negedge clk);
  endtask

  task automatic tally(ref int bad, input string tag);
    checks++;
    if (bad != 0) errors++;
    bad = 0;
  endtask

  task automatic check_frame(string tag);
    bad_rgb = 0; bad_sync = 0; bad_de = 0; bad_byte = 0;
    for (int i = 0; i < FRAME; i++) cyc(1);
    tally(bad_rgb, tag); tally(bad_sync, tag); tally(bad_de, tag); tally(bad_byte, tag);
  endtask

  task automatic step_layout();
    layout_step = 1'b1; cyc(0); layout_step = 1'b0; mlay = (mlay + 1) % 4;
  endtask

  task automatic step_color();
    color_step = 1'b1; cyc(0); color_step = 1'b0; mcol = (mcol + 1) % 4;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    mh = 0; mv = 0; mlay = 0; mcol = 0;
  endtask

  // {time, layout, scheme}
  localparam logic [27:0] VEC [8] = '{
    {24'h000000, 2'd0, 2'd0}, {24'h235959, 2'd1, 2'd1},
    {24'h123456, 2'd2, 2'd2}, {24'h090807, 2'd3, 2'd3},
    {24'hFFFFFF, 2'd0, 2'd0}, {24'h192837, 2'd2, 2'd1},
    {24'h2A5F6E, 2'd1, 2'd3}, {24'h101010, 2'd3, 2'd2}};

  initial begin
    do_reset();
    // R11 / R1: reset state at position (0,0)
    checks++;
    if (hsync !== 1'b1 || vsync !== 1'b1 || de !== 1'b1 || {red, green, blue} !== 6'b0) begin
      errors++;
      $display("FAIL R11 reset state: got h%b v%b de%b rgb%b exp h1 v1 de1 rgb000000", hsync, vsync, de, {red, green, blue});
    end
    for (int k = 0; k < 8; k++) begin
      digits = VEC[k][27:4];
      while (mlay != int'(VEC[k][3:2])) step_layout();   // R7 wrap
      while (mcol != int'(VEC[k][1:0])) step_color();    // R8 wrap
      check_frame("vector");
    end
    // R10: digits change mid-frame, model follows immediately
    bad_rgb = 0; bad_sync = 0; bad_de = 0; bad_byte = 0;
    for (int i = 0; i < FRAME; i++) begin
      if (i == FRAME / 3) digits = 24'h215938;
      cyc(1);
    end
    tally(bad_rgb, "R10"); tally(bad_sync, "R10"); tally(bad_de, "R10"); tally(bad_byte, "R10");
    // R7/R8: both steps in one cycle
    layout_step = 1'b1; color_step = 1'b1; cyc(0);
    layout_step = 1'b0; color_step = 1'b0;
    mlay = (mlay + 1) % 4; mcol = (mcol + 1) % 4;
    check_frame("R7 R8 together");
    // R11: reset mid-frame clears indices and beam
    for (int i = 0; i < 137; i++) cyc(0);
    do_reset();
    digits = 24'h235959;
    check_frame("R11 after reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule